// File: doc/BRIEF.md
# NAND Operation Bus Sequencer

This block executes a stream of flash operation steps on an asynchronous memory-mapped bus. Each step is one of five kinds: send a command byte, send a series of address bytes, move data from the flash window into a local buffer, move data from the buffer into the window, or wait until the flash reports ready. The steps are grouped into operations, and the last step of each operation carries a marker. The sequencer runs the steps strictly in order. When a step fails, every remaining step of that operation is swallowed without any bus traffic.

The command-latch, address-latch and die-select lines are not separate pins. They are offsets added to the bus address inside one flash window. The die base is the die index multiplied by a configurable stride, and the latch offsets are configurable masks with built-in defaults. For data steps, the bus access width is picked per step from the buffer byte address and the length, and the number of beats is scaled to match. Ready polling reads a status register in a separate register space at a fixed gap and gives up once a per-step budget is spent. Any step with a non-zero delay first issues a flushing read of register offset 0, and then idles for that many cycles.

Each operation ends with a one-cycle `op_done` pulse. `op_err` is high in that cycle if any step of the operation failed.

Top module: `nand_op_sequencer`

## Requirements
- R1: A command step (kind code 0) makes exactly one 8-bit write to window offset `die_base + cle_mask`, with the opcode in data bits 7:0.
- R2: An address step (kind 1) with N bytes makes N separate 8-bit writes to `die_base + ale_mask`, byte 0 (bits 7:0 of the address field) first.
- R3: A zero `cfg_cle_mask` selects the default offset 0x10, and a zero `cfg_ale_mask` selects the default offset 0x08. Non-zero values are used as given.
- R4: `die_base` equals the die index times `cfg_cs_stride`. With a zero stride, the die index has no effect on any bus address.
- R5: The width of a data step is 8 bits (size code 0) when force-8 is set or when the buffer address or length is odd. It is 16 bits (code 1) when both are even but either is not a multiple of 4. Otherwise it is 32 bits (code 2).
- R6: A data step makes `len / width_bytes` beats, all at window offset `die_base`, and the buffer pointer advances by the width on each beat. Kind 3 (data out) writes buffer bytes to the bus. Kind 2 (data in) stores bus bytes into the buffer. A length of 0 produces no access.
- R7: A wait step (kind 4) reads the status register (register space, offset `STATUS_OFS`) until bit 0 is 1. Consecutive polls are at least `POLL_GAP` idle cycles apart.
- R8: If a poll finds bit 0 clear after the step's timeout budget (in cycles) has run out, the wait step fails. With a budget of 0, the first clear poll fails.
- R9: A successful step with a non-zero delay is followed by a 32-bit read of register-space offset 0. After that read completes, at least `delay` cycles pass before the next step's first access.
- R10: After a failing step, the remaining steps of the operation make no bus access. The same applies to an unknown kind code, which fails.
- R11: `op_done` pulses for one cycle once per operation, after the step marked last. `op_err` is high only with `op_done`, and only when a step of that operation failed. A failure does not carry into the next operation.
- R12: Once raised, `bus_req` and all request fields stay stable until `bus_ack`.
- R13: After reset, `instr_ready` is 1, and `bus_req` and `op_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cle_mask | input | AW | Command-latch offset, 0 = default 0x10 |
| cfg_ale_mask | input | AW | Address-latch offset, 0 = default 0x08 |
| cfg_cs_stride | input | AW | Die stride, 0 = single die |
| instr_valid | input | 1 | Step offered |
| instr_ready | output | 1 | Step accepted when high with valid |
| instr_kind | input | 3 | 0 cmd, 1 addr, 2 data in, 3 data out, 4 wait |
| instr_die | input | CSW | Die index |
| instr_opcode | input | 8 | Command byte |
| instr_addr | input | 8*MAXA | Address bytes, byte 0 first |
| instr_naddr | input | NAW | Number of address bytes |
| instr_buf_addr | input | BAW | Buffer byte address for data steps |
| instr_len | input | LENW | Data length in bytes |
| instr_force8 | input | 1 | Force 8-bit data width |
| instr_timeout | input | TOW | Wait budget in cycles |
| instr_delay | input | DLW | Post-step delay in cycles |
| instr_last | input | 1 | Last step of the operation |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_space | output | 1 | 0 flash window, 1 register space |
| bus_addr | output | AW | Byte offset in the selected space |
| bus_size | output | 2 | 0 byte, 1 half, 2 word |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 32 | Read data, valid with ack |
| buf_addr | output | BAW | Buffer byte pointer |
| buf_size | output | 2 | Buffer access size code |
| buf_rdata | input | 32 | Buffer bytes at buf_addr, little-endian |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 32 | Buffer write data |
| op_done | output | 1 | Operation finished |
| op_err | output | 1 | Operation failed |

## Verification
The assertions assume that the bus returns `bus_ack` for one cycle only while `bus_req` is high, and that read data is valid in that cycle. The bench's bus model acknowledges each request one cycle after it is raised and drops the acknowledge in the cycle after that, so back-to-back beats never see a stale acknowledge. The alignment checks also assume that a step's buffer address and length do not change while the step runs. The bench changes these fields only between accepted steps and sweeps every low-bit combination of address and length, with force-8 both set and clear. The status model counts polls and raises bit 0 after a chosen number of them, so both ready and timeout endings occur.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [2:0] {
    K_CMD  = 3'd0,
    K_ADDR = 3'd1,
    K_DIN  = 3'd2,
    K_DOUT = 3'd3,
    K_WAIT = 3'd4
  } step_kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD,
    S_ADDR,
    S_XFER,
    S_POLL,
    S_GAP,
    S_FLUSH,
    S_DELAY
  } seq_state_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

endpackage

// File: rtl/nseq_rst_sync.sv
module nseq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/nseq_width_pick.sv
module nseq_width_pick #(
  parameter int LENW = 10
) (
  input  logic [1:0]      addr_lo,
  input  logic [LENW-1:0] len,
  input  logic            force8,
  output logic [1:0]      size,
  output logic [LENW-1:0] beats
);
  import nseq_pkg::*;

  logic [1:0] lo_or;

  always_comb begin
    lo_or = addr_lo | len[1:0];
    if (force8 || lo_or[0]) begin
      size  = SZ_B;
      beats = len;
    end else if (lo_or[1]) begin
      size  = SZ_H;
      beats = len >> 1;
    end else begin
      size  = SZ_W;
      beats = len >> 2;
    end
  end
endmodule

// File: rtl/nseq_addr_map.sv
module nseq_addr_map #(
  parameter int          AW      = 16,
  parameter int          CSW     = 2,
  parameter logic [AW-1:0] DEF_CLE = AW'(16'h0010),
  parameter logic [AW-1:0] DEF_ALE = AW'(16'h0008)
) (
  input  logic [CSW-1:0] die,
  input  logic [AW-1:0]  cle_mask,
  input  logic [AW-1:0]  ale_mask,
  input  logic [AW-1:0]  stride,
  output logic [AW-1:0]  data_ofs,
  output logic [AW-1:0]  cle_ofs,
  output logic [AW-1:0]  ale_ofs
);
  logic [AW-1:0] cle_eff, ale_eff;

  always_comb begin
    cle_eff  = (cle_mask == '0) ? DEF_CLE : cle_mask;
    ale_eff  = (ale_mask == '0) ? DEF_ALE : ale_mask;
    data_ofs = stride * AW'(die);
    cle_ofs  = data_ofs + cle_eff;
    ale_ofs  = data_ofs + ale_eff;
  end
endmodule

// File: rtl/nseq_down_cnt.sv
module nseq_down_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (step && (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer #(
  parameter int          AW         = 16,
  parameter int          CSW        = 2,
  parameter int          MAXA       = 5,
  parameter int          NAW        = $clog2(MAXA + 1),
  parameter int          BAW        = 8,
  parameter int          LENW       = 10,
  parameter int          TOW        = 16,
  parameter int          DLW        = 12,
  parameter int          POLL_GAP   = 6,
  parameter logic [AW-1:0] STATUS_OFS = AW'(16'h0040)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cfg_cle_mask,
  input  logic [AW-1:0]     cfg_ale_mask,
  input  logic [AW-1:0]     cfg_cs_stride,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [2:0]        instr_kind,
  input  logic [CSW-1:0]    instr_die,
  input  logic [7:0]        instr_opcode,
  input  logic [8*MAXA-1:0] instr_addr,
  input  logic [NAW-1:0]    instr_naddr,
  input  logic [BAW-1:0]    instr_buf_addr,
  input  logic [LENW-1:0]   instr_len,
  input  logic              instr_force8,
  input  logic [TOW-1:0]    instr_timeout,
  input  logic [DLW-1:0]    instr_delay,
  input  logic              instr_last,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_space,
  output logic [AW-1:0]     bus_addr,
  output logic [1:0]        bus_size,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic [BAW-1:0]    buf_addr,
  output logic [1:0]        buf_size,
  input  logic [31:0]       buf_rdata,
  output logic              buf_we,
  output logic [31:0]       buf_wdata,
  output logic              op_done,
  output logic              op_err
);
  import nseq_pkg::*;

  localparam int IDXW = LENW;
  localparam int GAPW = (DLW > $clog2(POLL_GAP + 1)) ? DLW : $clog2(POLL_GAP + 1);

  // reset release
  logic rst_s_n;
  nseq_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  // state and captured step
  seq_state_e        st_q, st_d;
  logic [IDXW-1:0]   idx_q, idx_d;
  logic              abort_q, abort_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              cap;

  logic [2:0]        c_kind_q;
  logic [CSW-1:0]    c_die_q;
  logic [7:0]        c_opc_q;
  logic [8*MAXA-1:0] c_addr_q;
  logic [NAW-1:0]    c_naddr_q;
  logic [BAW-1:0]    c_buf_q;
  logic [LENW-1:0]   c_len_q;
  logic              c_f8_q;
  logic [TOW-1:0]    c_tmo_q;
  logic [DLW-1:0]    c_dly_q;
  logic              c_last_q;

  // helpers
  logic [1:0]        x_size;
  logic [LENW-1:0]   x_beats;
  logic [AW-1:0]     ofs_data, ofs_cle, ofs_ale;
  logic [IDXW-1:0]   naddr_eff;
  logic [7:0]        abyte;
  logic              more_addr, more_beat;

  // timers
  logic              tm_load, tm_step, tm_done;
  logic [GAPW-1:0]   tm_val;
  logic              bud_load, bud_step, bud_gone;

  // completion
  logic              fin, fin_fail, ret, ret_fail, ret_last;

  nseq_width_pick #(.LENW(LENW)) u_wp (
    .addr_lo(c_buf_q[1:0]), .len(c_len_q), .force8(c_f8_q),
    .size(x_size), .beats(x_beats)
  );

  nseq_addr_map #(.AW(AW), .CSW(CSW)) u_am (
    .die(c_die_q), .cle_mask(cfg_cle_mask), .ale_mask(cfg_ale_mask),
    .stride(cfg_cs_stride), .data_ofs(ofs_data), .cle_ofs(ofs_cle),
    .ale_ofs(ofs_ale)
  );

  nseq_down_cnt #(.W(GAPW)) u_gap_tmr (
    .clk(clk), .rst_n(rst_s_n), .load(tm_load), .load_val(tm_val),
    .step(tm_step), .expired(tm_done)
  );

  nseq_down_cnt #(.W(TOW)) u_budget (
    .clk(clk), .rst_n(rst_s_n), .load(bud_load), .load_val(instr_timeout),
    .step(bud_step), .expired(bud_gone)
  );

  always_comb begin
    naddr_eff = (c_naddr_q > NAW'(MAXA)) ? IDXW'(MAXA) : IDXW'(c_naddr_q);
    more_addr = (idx_q < naddr_eff);
    more_beat = (idx_q < IDXW'(x_beats));
    abyte     = 8'h00;
    for (int k = 0; k < MAXA; k++) begin
      if (idx_q == IDXW'(k)) abyte = c_addr_q[8*k +: 8];
    end
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    abort_d  = abort_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    cap      = 1'b0;
    tm_load  = 1'b0;
    tm_val   = '0;
    tm_step  = 1'b0;
    bud_load = 1'b0;
    bud_step = 1'b0;
    fin      = 1'b0;
    fin_fail = 1'b0;
    ret      = 1'b0;
    ret_fail = 1'b0;
    ret_last = (st_q == S_IDLE) ? instr_last : c_last_q;

    unique case (st_q)
      S_IDLE: begin
        if (instr_valid) begin
          cap   = 1'b1;
          idx_d = '0;
          if (abort_q) begin
            ret = 1'b1;
          end else begin
            unique case (instr_kind)
              K_CMD:        st_d = S_CMD;
              K_ADDR:       st_d = S_ADDR;
              K_DIN, K_DOUT: st_d = S_XFER;
              K_WAIT: begin
                st_d     = S_POLL;
                bud_load = 1'b1;
              end
              default: begin
                ret      = 1'b1;
                ret_fail = 1'b1;
              end
            endcase
          end
        end
      end
      S_CMD: begin
        if (bus_ack) fin = 1'b1;
      end
      S_ADDR: begin
        if (!more_addr)   fin = 1'b1;
        else if (bus_ack) idx_d = idx_q + IDXW'(1);
      end
      S_XFER: begin
        if (!more_beat)   fin = 1'b1;
        else if (bus_ack) idx_d = idx_q + IDXW'(1);
      end
      S_POLL: begin
        bud_step = 1'b1;
        if (bus_ack) begin
          if (bus_rdata[0]) begin
            fin = 1'b1;
          end else if (bud_gone) begin
            fin      = 1'b1;
            fin_fail = 1'b1;
          end else begin
            st_d    = S_GAP;
            tm_load = 1'b1;
            tm_val  = GAPW'(POLL_GAP);
          end
        end
      end
      S_GAP: begin
        bud_step = 1'b1;
        if (tm_done) st_d = S_POLL;
        else         tm_step = 1'b1;
      end
      S_FLUSH: begin
        if (bus_ack) begin
          st_d    = S_DELAY;
          tm_load = 1'b1;
          tm_val  = GAPW'(c_dly_q);
        end
      end
      S_DELAY: begin
        if (tm_done) ret = 1'b1;
        else         tm_step = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase

    if (fin) begin
      if (!fin_fail && (c_dly_q != '0)) begin
        st_d = S_FLUSH;
      end else begin
        ret      = 1'b1;
        ret_fail = fin_fail;
      end
    end

    if (ret) begin
      st_d = S_IDLE;
      if (ret_last) begin
        done_d  = 1'b1;
        err_d   = abort_q | ret_fail;
        abort_d = 1'b0;
      end else begin
        abort_d = abort_q | ret_fail;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      abort_q <= abort_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // captured step fields, enabled on accept
  always_ff @(posedge clk) begin
    if (cap) begin
      c_kind_q  <= instr_kind;
      c_die_q   <= instr_die;
      c_opc_q   <= instr_opcode;
      c_addr_q  <= instr_addr;
      c_naddr_q <= instr_naddr;
      c_buf_q   <= instr_buf_addr;
      c_len_q   <= instr_len;
      c_f8_q    <= instr_force8;
      c_tmo_q   <= instr_timeout;
      c_dly_q   <= instr_delay;
      c_last_q  <= instr_last;
    end
  end

  // bus side
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_space = 1'b0;
    bus_addr  = '0;
    bus_size  = SZ_B;
    bus_wdata = 32'h0;
    unique case (st_q)
      S_CMD: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = ofs_cle;
        bus_wdata = {24'h0, c_opc_q};
      end
      S_ADDR: begin
        bus_req   = more_addr;
        bus_we    = 1'b1;
        bus_addr  = ofs_ale;
        bus_wdata = {24'h0, abyte};
      end
      S_XFER: begin
        bus_req   = more_beat;
        bus_we    = (c_kind_q == K_DOUT);
        bus_addr  = ofs_data;
        bus_size  = x_size;
        bus_wdata = buf_rdata;
      end
      S_POLL: begin
        bus_req   = 1'b1;
        bus_space = 1'b1;
        bus_addr  = STATUS_OFS;
        bus_size  = SZ_W;
      end
      S_FLUSH: begin
        bus_req   = 1'b1;
        bus_space = 1'b1;
        bus_size  = SZ_W;
      end
      default: ;
    endcase
  end

  // buffer side
  assign buf_addr  = c_buf_q + (BAW'(idx_q) << x_size);
  assign buf_size  = x_size;
  assign buf_we    = (st_q == S_XFER) && (c_kind_q == K_DIN) && more_beat && bus_ack;
  assign buf_wdata = bus_rdata;

  assign instr_ready = (st_q == S_IDLE);
  assign op_done     = done_q;
  assign op_err      = err_q;

  // the wait budget is held in u_budget; keep the captured copy for debug visibility
  logic unused_tmo;
  assign unused_tmo = ^c_tmo_q;
endmodule

// File: rtl/nseq_chk.sv
module nseq_chk #(
  parameter int BAW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_ack,
  input logic           bus_we,
  input logic           bus_space,
  input logic [15:0]    bus_addr,
  input logic [1:0]     bus_size,
  input logic [31:0]    bus_wdata,
  input logic [BAW-1:0] buf_addr,
  input logic           op_done,
  input logic           op_err,
  input logic           abort_q
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_space) && $stable(bus_size) && $stable(bus_wdata));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> op_done);

  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> !bus_req);

  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_space && bus_size == 2'd2 |-> buf_addr[1:0] == 2'b00);

  // R5
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_space && bus_size == 2'd1 |-> buf_addr[0] == 1'b0);
endmodule

bind nand_op_sequencer nseq_chk #(.BAW(BAW)) u_nseq_chk (
  .clk(clk), .rst_n(rst_s_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_we(bus_we), .bus_space(bus_space), .bus_addr(16'(bus_addr)),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .buf_addr(buf_addr),
  .op_done(op_done), .op_err(op_err), .abort_q(abort_q)
);

// File: tb/tb_nand_op_sequencer.sv
module tb_nand_op_sequencer;
  localparam int AW = 16, CSW = 2, MAXA = 5, NAW = 3, BAW = 8, LENW = 10;
  localparam int TOW = 16, DLW = 12, GAP = 6;
  localparam logic [15:0] STAT = 16'h0040;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] cfg_cle_mask, cfg_ale_mask, cfg_cs_stride;
  logic instr_valid, instr_ready, instr_force8, instr_last;
  logic [2:0] instr_kind;
  logic [CSW-1:0] instr_die;
  logic [7:0] instr_opcode;
  logic [8*MAXA-1:0] instr_addr;
  logic [NAW-1:0] instr_naddr;
  logic [BAW-1:0] instr_buf_addr;
  logic [LENW-1:0] instr_len;
  logic [TOW-1:0] instr_timeout;
  logic [DLW-1:0] instr_delay;
  logic bus_req, bus_we, bus_space, bus_ack, buf_we, op_done, op_err;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_size, buf_size;
  logic [31:0] bus_wdata, bus_rdata, buf_rdata, buf_wdata;
  logic [BAW-1:0] buf_addr;

  nand_op_sequencer dut (.*);

  logic [7:0] mem [256];
  assign buf_rdata = {mem[8'(buf_addr + 3)], mem[8'(buf_addr + 2)],
                      mem[8'(buf_addr + 1)], mem[buf_addr]};

  int lg_n, cyc, polls, ready_after, done_cnt, n_chk, n_fail;
  logic last_err;
  logic        lg_we [256];
  logic        lg_sp [256];
  logic [15:0] lg_ad [256];
  logic [1:0]  lg_sz [256];
  logic [31:0] lg_wd [256];
  logic [31:0] lg_rd [256];
  int          lg_t  [256];

  function automatic logic [31:0] rpat(int n);
    return {8'(n * 3 + 1), 8'(n * 5 + 2), 8'(n * 7 + 3), 8'(n * 11 + 4)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (op_done) begin done_cnt = done_cnt + 1; last_err = op_err; end
    if (buf_we) begin
      for (int j = 0; j < 4; j++)
        if (j < (1 << buf_size)) mem[8'(buf_addr + j)] <= buf_wdata[8*j +: 8];
    end
    if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_space && !bus_we && bus_addr == STAT) begin
        bus_rdata <= {31'h0, polls >= ready_after};
        lg_rd[lg_n] = {31'h0, polls >= ready_after};
        polls = polls + 1;
      end else begin
        bus_rdata <= rpat(lg_n);
        lg_rd[lg_n] = rpat(lg_n);
      end
      lg_we[lg_n] = bus_we; lg_sp[lg_n] = bus_space; lg_ad[lg_n] = bus_addr;
      lg_sz[lg_n] = bus_size; lg_wd[lg_n] = bus_wdata; lg_t[lg_n] = cyc;
      lg_n = (lg_n + 1) % 256;
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic last);
    while (!instr_ready) @(negedge clk);
    instr_kind = k; instr_last = last; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int wbytes(input int a, input int l, input bit f);
    if (f || ((a | l) & 1)) return 1;
    if ((a | l) & 2) return 2;
    return 4;
  endfunction

  int ops;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    int w, nb, t0;
    logic [31:0] m, e;
    lg_n = 0; cyc = 0; polls = 0; ready_after = 0; done_cnt = 0; n_chk = 0; n_fail = 0;
    bus_ack = 1'b0; bus_rdata = '0; ops = 0; last_err = 1'b0;
    cfg_cle_mask = '0; cfg_ale_mask = '0; cfg_cs_stride = '0;
    instr_valid = 0; instr_kind = 0; instr_die = 0; instr_opcode = 0; instr_addr = '0;
    instr_naddr = 0; instr_buf_addr = 0; instr_len = 0; instr_force8 = 0;
    instr_timeout = 0; instr_delay = 0; instr_last = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13
    chk(instr_ready && !bus_req && !op_done, "R13", "reset state",
        {instr_ready, bus_req, op_done}, 3'b100);

    // R1 R3 default masks
    lg_n = 0; instr_opcode = 8'h70; push(3'd0, 1); ops++; wait_done(ops);
    chk(lg_n == 1 && lg_we[0] && !lg_sp[0] && lg_ad[0] == 16'h10 && lg_sz[0] == 0
        && lg_wd[0][7:0] == 8'h70, "R1", "cmd write", lg_ad[0], 16'h10);
    chk(!last_err, "R11", "cmd err", last_err, 0);

    // R2 address bytes in order
    lg_n = 0; instr_addr = 40'h55_44_33_22_11; instr_naddr = 5; push(3'd1, 1); ops++; wait_done(ops);
    ok = (lg_n == 5);
    for (int k = 0; k < 5; k++)
      ok &= lg_we[k] && lg_ad[k] == 16'h08 && lg_sz[k] == 0 && lg_wd[k][7:0] == 8'(8'h11 * (k + 1));
    chk(ok, "R2", "addr cycles", lg_n, 5);

    // R3 overrides
    cfg_cle_mask = 16'h0002; cfg_ale_mask = 16'h0004;
    lg_n = 0; instr_naddr = 2; push(3'd0, 0); push(3'd1, 1); ops++; wait_done(ops);
    chk(lg_n == 3 && lg_ad[0] == 16'h2 && lg_ad[1] == 16'h4 && lg_ad[2] == 16'h4,
        "R3", "override masks", lg_ad[0], 2);
    cfg_cle_mask = '0; cfg_ale_mask = '0;

    // R4 die stride
    for (int s = 0; s < 2; s++) begin
      cfg_cs_stride = (s == 0) ? 16'h0000 : 16'h0100;
      for (int d = 0; d < 4; d++) begin
        lg_n = 0; instr_die = 2'(d); push(3'd0, 1); ops++; wait_done(ops);
        chk(lg_n == 1 && lg_ad[0] == 16'(d * cfg_cs_stride + 16'h10), "R4", "die base",
            lg_ad[0], d * cfg_cs_stride + 16'h10);
      end
    end
    cfg_cs_stride = '0; instr_die = 0;

    // R5 R6 data-out sweep
    for (int a = 0; a < 4; a++)
      for (int l = 0; l < 9; l++)
        for (int f = 0; f < 2; f++) begin
          lg_n = 0; instr_buf_addr = 8'(a); instr_len = 10'(l); instr_force8 = f[0];
          push(3'd3, 1); ops++; wait_done(ops);
          w = wbytes(a, l, f[0]); nb = l / w;
          m = (w == 4) ? 32'hFFFFFFFF : ((w == 2) ? 32'h0000FFFF : 32'h000000FF);
          ok = (lg_n == nb);
          for (int k = 0; k < nb; k++) begin
            e = 0;
            for (int j = 0; j < w; j++) e |= 32'(mem[a + k * w + j]) << (8 * j);
            ok &= lg_we[k] && !lg_sp[k] && lg_ad[k] == 0 && lg_sz[k] == 2'($clog2(w))
                  && ((lg_wd[k] & m) == e);
          end
          chk(ok, "R5", "data out width/beats", lg_n, nb);
        end

    // R6 data-in sweep
    for (int a = 0; a < 4; a++)
      for (int l = 0; l < 9; l++)
        for (int f = 0; f < 2; f++) begin
          for (int i = 0; i < 16; i++) mem[i] = 8'hEE;
          lg_n = 0; instr_buf_addr = 8'(a); instr_len = 10'(l); instr_force8 = f[0];
          push(3'd2, 1); ops++; wait_done(ops);
          w = wbytes(a, l, f[0]); nb = l / w;
          ok = (lg_n == nb);
          for (int k = 0; k < nb; k++) ok &= !lg_we[k] && lg_sz[k] == 2'($clog2(w));
          for (int i = 0; i < 16; i++) begin
            e = 32'hEE;
            if (i >= a && i < a + nb * w) e = 32'(rpat((i - a) / w) >> (8 * ((i - a) % w))) & 32'hFF;
            ok &= (mem[i] == e[7:0]);
          end
          chk(ok, "R6", "data in buffer", lg_n, nb);
        end
    instr_force8 = 0; instr_len = 0;

    // R7 ready after three clear polls
    lg_n = 0; polls = 0; ready_after = 3; instr_timeout = 16'd1000;
    push(3'd4, 1); ops++; wait_done(ops);
    ok = (lg_n == 4);
    for (int k = 0; k < 4; k++) ok &= lg_sp[k] && !lg_we[k] && lg_ad[k] == STAT;
    for (int k = 1; k < 4; k++) ok &= (lg_t[k] - lg_t[k-1]) >= GAP + 1;
    chk(ok, "R7", "poll count/gap", lg_n, 4);
    chk(!last_err, "R7", "wait ok", last_err, 0);

    // R8 zero budget
    lg_n = 0; polls = 0; ready_after = 1000; instr_timeout = 0;
    push(3'd4, 1); ops++; wait_done(ops);
    chk(lg_n == 1 && last_err, "R8", "zero budget fail", lg_n, 1);
    // R8 finite budget
    lg_n = 0; polls = 0; instr_timeout = 16'd40;
    push(3'd4, 1); ops++; wait_done(ops);
    chk(last_err && lg_n >= 2 && lg_n <= 40 / GAP + 2, "R8", "budget fail", lg_n, 40 / GAP);

    // R9 delay
    lg_n = 0; instr_delay = 12'd20; instr_opcode = 8'hA5; push(3'd0, 0);
    instr_delay = 0; push(3'd0, 1); ops++; wait_done(ops);
    t0 = lg_t[1];
    chk(lg_n == 3 && lg_sp[1] && !lg_we[1] && lg_ad[1] == 0 && lg_sz[1] == 2,
        "R9", "flush read", lg_ad[1], 0);
    chk((lg_t[2] - t0) >= 21 && (lg_t[2] - t0) <= 30, "R9", "delay gap", lg_t[2] - t0, 21);

    // R10 abort after failed wait
    lg_n = 0; polls = 0; ready_after = 1000; instr_timeout = 0;
    push(3'd4, 0); push(3'd0, 0); push(3'd1, 0); push(3'd3, 1); ops++; wait_done(ops);
    chk(lg_n == 1 && last_err, "R10", "abort silent", lg_n, 1);
    chk(done_cnt == ops, "R11", "one done per op", done_cnt, ops);
    lg_n = 0; push(3'd0, 1); ops++; wait_done(ops);
    chk(lg_n == 1 && !last_err, "R11", "error cleared", last_err, 0);
    // R10 unknown kind
    lg_n = 0; push(3'd6, 0); push(3'd0, 1); ops++; wait_done(ops);
    chk(lg_n == 0 && last_err, "R10", "unknown kind", lg_n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule